// File: doc/BRIEF.md
# Serial port control and status register file

This block is the register front end of a FIFO-based serial port. It stores the mode, bit-rate, control, port and FIFO-control settings, and it keeps five event flags in a status register. Flags are raised by pulses from the transmit and receive datapaths. Software clears a flag by writing a zero to its bit, while a one written to a bit leaves that flag as it is. Some flags are also raised as a side effect of bus accesses. A status read with the transmitter enabled marks the transmitter idle, and a control write that disables the transmitter does the same.

The bus is a plain single-cycle register port. Write data is taken at the clock edge. Read data is combinational from the address while the read strobe is high, and any side effect of a read lands at the same edge. The block does not serialise bits, generate baud clocks or store received bytes. It forwards the written transmit byte with a strobe. It presents the FIFO's head byte and fill level for reading, pulses a pop when the receive byte is read, and hands the decoded trigger level and a FIFO-flush pulse to the FIFO.

Top module: `serstat_regs`

## Requirements
- R1: After reset the registers read as follows: mode 0x00 at offset 0x00, bit rate 0xFF at 0x04, control 0x20 at 0x08, FIFO control 0x0000 at 0x18, port 0x00 at 0x20 and status 0x0060 at 0x10. Both interrupt outputs are low.
- R2: Writes keep only the writable bits of each register. Mode keeps bits 0x7B and control keeps bits 0xFA. Port keeps bits 0xF3. Bit rate keeps all 8 low bits and FIFO control keeps all 16 bits.
- R3: The status register places the flags as follows: data-ready at bit 0, receive-full at bit 1, break at bit 4, transmit-empty at bit 5 and transmit-end at bit 6. Every other bit reads 0. A pulse on `ev_rx_ready`, `ev_rx_full` or `ev_brk` sets data-ready, receive-full or break respectively.
- R4: A status write clears each flag whose bit in the written word is 0 and leaves each flag whose bit is 1. Bits outside the five flag positions have no effect.
- R5: `rx_irq` rises the cycle after an `ev_rx_full` pulse while control bit 6 is 1. It falls after a status write with bit 0 or bit 1 equal to 0, or after a control write with bit 6 equal to 0.
- R6: `tx_irq` follows control bit 7. A control write with bit 5 equal to 0 sets transmit-end.
- R7: A status read while control bit 5 is 1 returns the flags as they were before the read, and then sets transmit-empty and transmit-end.
- R8: A write to offset 0x0C drives `tx_strobe` high for that cycle and presents the low byte on `tx_byte` from the next cycle. It also reads back at 0x0C and clears transmit-empty.
- R9: FIFO-control bits 7:6 select `rx_trig`: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. A FIFO-control write with bit 1 equal to 1 drives `fifo_clear` high for that cycle.
- R10: A read of 0x14 returns `rx_data` and drives `rx_pop` high for that cycle. A read of 0x1C returns `rx_level` and does not pop.
- R11: Offset 0x24 and every unmapped offset read as 0. Writes to them change no register, flag or output.
- R12: When a flag set (event pulse or access side effect) and a clear fall in the same cycle, the set wins. The same holds for `rx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (16) | Read data, zero when no read |
| ev_brk | input | 1 | Break detected pulse |
| ev_rx_full | input | 1 | Receive FIFO reached trigger level pulse |
| ev_rx_ready | input | 1 | Receive data ready pulse |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_level | input | LVL_W (5) | Receive FIFO fill level |
| rx_pop | output | 1 | Receive byte consumed |
| rx_trig | output | TRIG_W (4) | Decoded receive trigger level |
| fifo_clear | output | 1 | Receive FIFO flush pulse |
| tx_byte | output | 8 | Last written transmit byte |
| tx_strobe | output | 1 | Transmit byte written pulse |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The collision that matters is an event pulse arriving in the same cycle as the status write that clears the same flag. The same applies to an `ev_rx_full` pulse arriving while a control or status write drops `rx_irq`. The bench drives the bus write and all three event inputs in one cycle. It then reads the status word in the next cycle and expects the raised bits to survive and the interrupt to stay high. The clear-on-zero rule is swept over all 32 combinations of the five flag bits, and the address space is swept across every offset.

// File: rtl/serstat_pkg.sv
package serstat_pkg;

   localparam int FLAG_N = 5;

   // flag slots in the internal vector
   localparam int FL_DR   = 0;
   localparam int FL_RDF  = 1;
   localparam int FL_BRK  = 2;
   localparam int FL_TDE  = 3;
   localparam int FL_TEND = 4;

   // register byte offsets
   localparam int OFS_MODE = 'h00;
   localparam int OFS_RATE = 'h04;
   localparam int OFS_CTRL = 'h08;
   localparam int OFS_TXD  = 'h0C;
   localparam int OFS_STAT = 'h10;
   localparam int OFS_RXD  = 'h14;
   localparam int OFS_FCTL = 'h18;
   localparam int OFS_RCNT = 'h1C;
   localparam int OFS_PORT = 'h20;
   localparam int OFS_LINE = 'h24;

   // bit position of each flag slot in the status word
   function automatic int flag_pos(input int slot);
      case (slot)
         FL_DR:   return 0;
         FL_RDF:  return 1;
         FL_BRK:  return 4;
         FL_TDE:  return 5;
         default: return 6;
      endcase
   endfunction

endpackage

// File: rtl/serstat_field.sv
module serstat_field #(
   parameter int           W    = 8,
   parameter logic [W-1:0] MASK = '1,
   parameter logic [W-1:0] RST  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wd,
   output logic [W-1:0] q
);

   initial begin
      assert (W > 0) else $error("serstat_field: W must be positive");
      assert ((RST & ~MASK) == '0) else $error("serstat_field: reset value outside mask");
   end

   generate
      if (MASK == {W{1'b1}}) begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= RST;
            else if (we) q <= wd;
         end
      end else begin : g_masked
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= RST;
            else if (we) q <= wd & MASK;
         end
      end
   endgenerate

endmodule

// File: rtl/serstat_flags.sv
module serstat_flags #(
   parameter int           N   = 5,
   parameter logic [N-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);

   initial begin
      assert (N > 0) else $error("serstat_flags: N must be positive");
   end

   generate
      for (genvar g = 0; g < N; g++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[g] <= RST[g];
            else if (set[g]) q[g] <= 1'b1;
            else if (clr[g]) q[g] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/serstat_trig.sv
module serstat_trig #(
   parameter int TW = 4,
   parameter int L0 = 1,
   parameter int L1 = 4,
   parameter int L2 = 8,
   parameter int L3 = 14
) (
   input  logic [1:0]    sel,
   output logic [TW-1:0] lvl
);

   initial begin
      assert (L0 < 2**TW && L1 < 2**TW && L2 < 2**TW && L3 < 2**TW)
         else $error("serstat_trig: level does not fit TW");
   end

   always_comb begin
      case (sel)
         2'd0:    lvl = TW'(L0);
         2'd1:    lvl = TW'(L1);
         2'd2:    lvl = TW'(L2);
         default: lvl = TW'(L3);
      endcase
   end

endmodule

// File: rtl/serstat_regs.sv
module serstat_regs
   import serstat_pkg::*;
#(
   parameter int       ADDR_W    = 6,
   parameter int       DATA_W    = 16,
   parameter int       LVL_W     = 5,
   parameter int       TRIG_W    = 4,
   parameter int       FCTL_W    = 16,
   parameter logic [7:0] MODE_MASK = 8'h7B,
   parameter logic [7:0] CTRL_MASK = 8'hFA,
   parameter logic [7:0] PORT_MASK = 8'hF3,
   parameter logic [7:0] RATE_RST  = 8'hFF,
   parameter logic [7:0] CTRL_RST  = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_brk,
   input  logic              ev_rx_full,
   input  logic              ev_rx_ready,
   input  logic [7:0]        rx_data,
   input  logic [LVL_W-1:0]  rx_level,
   output logic              rx_pop,
   output logic [TRIG_W-1:0] rx_trig,
   output logic              fifo_clear,
   output logic [7:0]        tx_byte,
   output logic              tx_strobe,
   output logic              tx_irq,
   output logic              rx_irq
);

   localparam int CTRL_TXEN = 5;
   localparam int CTRL_RXIE = 6;
   localparam int CTRL_TXIE = 7;
   localparam logic [FLAG_N-1:0] FLAG_RST = FLAG_N'((1 << FL_TDE) | (1 << FL_TEND));

   initial begin
      assert (ADDR_W >= 6) else $error("serstat_regs: ADDR_W too small for the map");
      assert (DATA_W >= 16 && FCTL_W <= DATA_W) else $error("serstat_regs: DATA_W too small");
      assert (LVL_W <= DATA_W) else $error("serstat_regs: LVL_W wider than data");
   end

   // address decode
   logic sel_mode, sel_rate, sel_ctrl, sel_txd, sel_stat;
   logic sel_rxd, sel_fctl, sel_rcnt, sel_port, sel_line, sel_hit;

   assign sel_mode = (bus_addr == ADDR_W'(OFS_MODE));
   assign sel_rate = (bus_addr == ADDR_W'(OFS_RATE));
   assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_txd  = (bus_addr == ADDR_W'(OFS_TXD));
   assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign sel_rxd  = (bus_addr == ADDR_W'(OFS_RXD));
   assign sel_fctl = (bus_addr == ADDR_W'(OFS_FCTL));
   assign sel_rcnt = (bus_addr == ADDR_W'(OFS_RCNT));
   assign sel_port = (bus_addr == ADDR_W'(OFS_PORT));
   assign sel_line = (bus_addr == ADDR_W'(OFS_LINE));
   assign sel_hit  = sel_mode | sel_rate | sel_ctrl | sel_txd | sel_stat |
                     sel_rxd | sel_fctl | sel_rcnt | sel_port | sel_line;

   logic wr_ctrl, wr_txd, wr_stat, wr_fctl, rd_stat, rd_rxd;
   assign wr_ctrl = bus_wr & sel_ctrl;
   assign wr_txd  = bus_wr & sel_txd;
   assign wr_stat = bus_wr & sel_stat;
   assign wr_fctl = bus_wr & sel_fctl;
   assign rd_stat = bus_rd & sel_stat;
   assign rd_rxd  = bus_rd & sel_rxd;

   // configuration registers
   logic [7:0]        mode_q, rate_q, ctrl_q, port_q, txd_q;
   logic [FCTL_W-1:0] fctl_q;

   serstat_field #(.W(8), .MASK(MODE_MASK), .RST(8'h00)) i_mode (
      .clk(clk), .rst_n(rst_n), .we(bus_wr & sel_mode), .wd(bus_wdata[7:0]), .q(mode_q));
   serstat_field #(.W(8), .MASK(8'hFF), .RST(RATE_RST)) i_rate (
      .clk(clk), .rst_n(rst_n), .we(bus_wr & sel_rate), .wd(bus_wdata[7:0]), .q(rate_q));
   serstat_field #(.W(8), .MASK(CTRL_MASK), .RST(CTRL_RST)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .we(wr_ctrl), .wd(bus_wdata[7:0]), .q(ctrl_q));
   serstat_field #(.W(8), .MASK(PORT_MASK), .RST(8'h00)) i_port (
      .clk(clk), .rst_n(rst_n), .we(bus_wr & sel_port), .wd(bus_wdata[7:0]), .q(port_q));
   serstat_field #(.W(8), .MASK(8'hFF), .RST(8'h00)) i_txd (
      .clk(clk), .rst_n(rst_n), .we(wr_txd), .wd(bus_wdata[7:0]), .q(txd_q));
   serstat_field #(.W(FCTL_W), .MASK({FCTL_W{1'b1}}), .RST('0)) i_fctl (
      .clk(clk), .rst_n(rst_n), .we(wr_fctl), .wd(bus_wdata[FCTL_W-1:0]), .q(fctl_q));

   // event flags
   logic [FLAG_N-1:0] flag_set, flag_clr, flag_q;
   logic              txidle_set;

   assign txidle_set = rd_stat & ctrl_q[CTRL_TXEN];

   always_comb begin
      flag_set          = '0;
      flag_set[FL_DR]   = ev_rx_ready;
      flag_set[FL_RDF]  = ev_rx_full;
      flag_set[FL_BRK]  = ev_brk;
      flag_set[FL_TDE]  = txidle_set;
      flag_set[FL_TEND] = txidle_set | (wr_ctrl & ~bus_wdata[CTRL_TXEN]);
      for (int i = 0; i < FLAG_N; i++)
         flag_clr[i] = wr_stat & ~bus_wdata[flag_pos(i)];
      flag_clr[FL_TDE] = flag_clr[FL_TDE] | wr_txd;
   end

   serstat_flags #(.N(FLAG_N), .RST(FLAG_RST)) i_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .q(flag_q));

   logic [DATA_W-1:0] stat_word;
   always_comb begin
      stat_word = '0;
      for (int i = 0; i < FLAG_N; i++)
         stat_word[flag_pos(i)] = flag_q[i];
   end

   // receive interrupt: set beats clear
   logic rxirq_set, rxirq_clr;
   assign rxirq_set = ev_rx_full & ctrl_q[CTRL_RXIE];
   assign rxirq_clr = (wr_stat & ~(bus_wdata[1] & bus_wdata[0])) |
                      (wr_ctrl & ~bus_wdata[CTRL_RXIE]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rx_irq <= 1'b0;
      else if (rxirq_set) rx_irq <= 1'b1;
      else if (rxirq_clr) rx_irq <= 1'b0;
   end

   serstat_trig #(.TW(TRIG_W)) i_trig (.sel(fctl_q[7:6]), .lvl(rx_trig));

   assign tx_irq     = ctrl_q[CTRL_TXIE];
   assign tx_byte    = txd_q;
   assign tx_strobe  = wr_txd;
   assign fifo_clear = wr_fctl & bus_wdata[1];
   assign rx_pop     = rd_rxd;

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (1'b1)
            sel_mode: bus_rdata = DATA_W'(mode_q);
            sel_rate: bus_rdata = DATA_W'(rate_q);
            sel_ctrl: bus_rdata = DATA_W'(ctrl_q);
            sel_txd:  bus_rdata = DATA_W'(txd_q);
            sel_stat: bus_rdata = stat_word;
            sel_rxd:  bus_rdata = DATA_W'(rx_data);
            sel_fctl: bus_rdata = DATA_W'(fctl_q);
            sel_rcnt: bus_rdata = DATA_W'(rx_level);
            sel_port: bus_rdata = DATA_W'(port_q);
            default:  bus_rdata = '0;
         endcase
      end
   end

   // assertions
   a_r3_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_brk |=> flag_q[FL_BRK]);

   a_r6_txirq_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) |=> tx_irq == $past(bus_wdata[7]));

   a_r8_txd_empties: assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe |=> !flag_q[FL_TDE]);

   a_r5_rxirq_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[1:0] != 2'b11 && !ev_rx_full)
      |=> !rx_irq);

   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rx_full && ctrl_q[CTRL_RXIE]) |=> rx_irq);

   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !sel_hit) |-> bus_rdata == '0);

endmodule

// File: tb/test_serstat_regs.sv
module test_serstat_regs;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_rdata;
   logic        ev_brk = 1'b0, ev_rx_full = 1'b0, ev_rx_ready = 1'b0;
   logic [7:0]  rx_data = '0;
   logic [4:0]  rx_level = '0;
   logic        rx_pop, fifo_clear, tx_strobe, tx_irq, rx_irq;
   logic [3:0]  rx_trig;
   logic [7:0]  tx_byte;

   int total = 0;
   int bad = 0;

   serstat_regs i_serstat_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ev_brk(ev_brk), .ev_rx_full(ev_rx_full), .ev_rx_ready(ev_rx_ready),
      .rx_data(rx_data), .rx_level(rx_level), .rx_pop(rx_pop), .rx_trig(rx_trig),
      .fifo_clear(fifo_clear), .tx_byte(tx_byte), .tx_strobe(tx_strobe),
      .tx_irq(tx_irq), .rx_irq(rx_irq));

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 1'b0;
   endtask

   task automatic rdchk(input string req, input logic [5:0] a, input logic [15:0] exp);
      logic [15:0] d;
      rd(a, d);
      chk(req, {16'h0, d}, {16'h0, exp});
   endtask

   task automatic pulse(input logic b, input logic f, input logic r);
      @(negedge clk);
      ev_brk = b; ev_rx_full = f; ev_rx_ready = r;
      @(posedge clk);
      #1 begin ev_brk = 1'b0; ev_rx_full = 1'b0; ev_rx_ready = 1'b0; end
   endtask

   function automatic bit is_mapped(input int a);
      return a == 'h00 || a == 'h04 || a == 'h08 || a == 'h0C || a == 'h10 ||
             a == 'h14 || a == 'h18 || a == 'h1C || a == 'h20 || a == 'h24;
   endfunction

   initial begin
      #(CLK_P * 150000);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [15:0] w;
      logic [15:0] tv [4];
      tv[0] = 1; tv[1] = 4; tv[2] = 8; tv[3] = 14;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      chk("R1 tx_irq", {31'h0, tx_irq}, 0);
      chk("R1 rx_irq", {31'h0, rx_irq}, 0);
      rdchk("R1 mode", 6'h00, 16'h0000);
      rdchk("R1 rate", 6'h04, 16'h00FF);
      rdchk("R1 ctrl", 6'h08, 16'h0020);
      rdchk("R1 fifo ctrl", 6'h18, 16'h0000);
      rdchk("R1 port", 6'h20, 16'h0000);
      rdchk("R1 status", 6'h10, 16'h0060);

      // R2 / R6 sweep of masked writes
      for (int v = 0; v < 256; v++) begin
         wr(6'h00, 16'hFF00 | 16'(v));
         rdchk("R2 mode mask", 6'h00, 16'(v) & 16'h007B);
         wr(6'h04, 16'(v));
         rdchk("R2 rate", 6'h04, 16'(v));
         wr(6'h20, 16'(v));
         rdchk("R2 port mask", 6'h20, 16'(v) & 16'h00F3);
         wr(6'h08, 16'(v));
         rdchk("R2 ctrl mask", 6'h08, 16'(v) & 16'h00FA);
         chk("R6 tx_irq follows ctrl bit 7", {31'h0, tx_irq}, (v >> 7) & 1);
      end
      wr(6'h18, 16'hA5C3);
      rdchk("R2 fifo ctrl full width", 6'h18, 16'hA5C3);

      // R6 transmit-end set by control write with bit 5 low
      wr(6'h08, 16'h0000);
      wr(6'h10, 16'h0000);
      rdchk("R4 all cleared", 6'h10, 16'h0000);
      wr(6'h08, 16'h0000);
      rdchk("R6 tend set by ctrl write", 6'h10, 16'h0040);
      wr(6'h10, 16'h0000);

      // R3 event flags
      pulse(0, 0, 1);
      rdchk("R3 data-ready bit 0", 6'h10, 16'h0001);
      pulse(0, 1, 0);
      rdchk("R3 receive-full bit 1", 6'h10, 16'h0003);
      chk("R5 no irq with bit 6 low", {31'h0, rx_irq}, 0);
      pulse(1, 0, 0);
      rdchk("R3 break bit 4", 6'h10, 16'h0013);

      // R4 exhaustive clear-on-zero sweep
      for (int m = 0; m < 32; m++) begin
         wr(6'h08, 16'h0020);
         rd(6'h10, d);
         wr(6'h08, 16'h0000);
         pulse(1, 1, 1);
         rdchk("R4 all flags up", 6'h10, 16'h0073);
         w = (m[0] ? 16'hFF8C : 16'h0000) |
             (16'(m[0]) << 0) | (16'(m[1]) << 1) | (16'(m[2]) << 4) |
             (16'(m[3]) << 5) | (16'(m[4]) << 6);
         wr(6'h10, w);
         rdchk("R4 clear-on-zero", 6'h10, w & 16'h0073);
      end

      // R5 receive interrupt
      wr(6'h10, 16'h0000);
      wr(6'h08, 16'h0040);
      pulse(0, 1, 0);
      #1 chk("R5 rx_irq raised", {31'h0, rx_irq}, 1);
      wr(6'h10, 16'hFFFF);
      #1 chk("R5 all-ones status write keeps irq", {31'h0, rx_irq}, 1);
      wr(6'h10, 16'hFFFE);
      #1 chk("R5 bit 0 zero drops irq", {31'h0, rx_irq}, 0);
      pulse(0, 1, 0);
      wr(6'h10, 16'hFFFD);
      #1 chk("R5 bit 1 zero drops irq", {31'h0, rx_irq}, 0);
      pulse(0, 1, 0);
      wr(6'h08, 16'h0000);
      #1 chk("R5 ctrl bit 6 zero drops irq", {31'h0, rx_irq}, 0);
      pulse(0, 1, 0);
      #1 chk("R5 disabled irq stays low", {31'h0, rx_irq}, 0);

      // R7 status read side effect
      wr(6'h10, 16'h0000);
      wr(6'h08, 16'h0020);
      rdchk("R7 read returns old value", 6'h10, 16'h0000);
      rdchk("R7 flags set after read", 6'h10, 16'h0060);
      wr(6'h08, 16'h0000);
      wr(6'h10, 16'h0000);
      rdchk("R7 no side effect when disabled", 6'h10, 16'h0000);
      rdchk("R7 still clear", 6'h10, 16'h0000);

      // R8 transmit data
      wr(6'h08, 16'h0020);
      rd(6'h10, d);
      wr(6'h08, 16'h0000);
      rdchk("R8 idle before write", 6'h10, 16'h0060);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 6'h0C; bus_wdata = 16'h01A5;
      #1 chk("R8 strobe high", {31'h0, tx_strobe}, 1);
      @(posedge clk);
      #1 bus_wr = 1'b0;
      #1 chk("R8 strobe one cycle", {31'h0, tx_strobe}, 0);
      chk("R8 tx_byte", {24'h0, tx_byte}, 32'hA5);
      rdchk("R8 transmit-empty cleared", 6'h10, 16'h0040);
      rdchk("R8 data reads back", 6'h0C, 16'h00A5);

      // R9 trigger decode and flush
      for (int t = 0; t < 4; t++) begin
         wr(6'h18, 16'h0100 | 16'(t << 6));
         #1 chk("R9 trigger level", {28'h0, rx_trig}, {16'h0, tv[t]});
         rdchk("R9 fifo ctrl readback", 6'h18, 16'h0100 | 16'(t << 6));
      end
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 6'h18; bus_wdata = 16'h0002;
      #1 chk("R9 flush pulse", {31'h0, fifo_clear}, 1);
      @(posedge clk);
      #1 bus_wr = 1'b0;
      #1 chk("R9 flush ends", {31'h0, fifo_clear}, 0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 6'h18; bus_wdata = 16'h00FD;
      #1 chk("R9 no flush with bit 1 low", {31'h0, fifo_clear}, 0);
      @(posedge clk);
      #1 bus_wr = 1'b0;

      // R10 receive data and level
      rx_data = 8'h5C; rx_level = 5'd9;
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 6'h14;
      #1 chk("R10 receive byte", {16'h0, bus_rdata}, 32'h5C);
      chk("R10 pop on data read", {31'h0, rx_pop}, 1);
      @(posedge clk);
      #1 bus_rd = 1'b0;
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 6'h1C;
      #1 chk("R10 receive level", {16'h0, bus_rdata}, 32'd9);
      chk("R10 no pop on level read", {31'h0, rx_pop}, 0);
      @(posedge clk);
      #1 bus_rd = 1'b0;

      // R11 unmapped and line status
      wr(6'h10, 16'h0000);
      wr(6'h00, 16'h007B);
      wr(6'h04, 16'h003C);
      wr(6'h20, 16'h00F3);
      wr(6'h08, 16'h0080);
      pulse(1, 1, 1);
      for (int a = 0; a < 64; a++)
         if (!is_mapped(a) || a == 'h24) wr(6'(a), 16'h0000);
      for (int a = 0; a < 64; a++)
         if (!is_mapped(a) || a == 'h24) rdchk("R11 reads zero", 6'(a), 16'h0000);
      rdchk("R11 mode untouched", 6'h00, 16'h007B);
      rdchk("R11 rate untouched", 6'h04, 16'h003C);
      rdchk("R11 ctrl untouched", 6'h08, 16'h0080);
      rdchk("R11 port untouched", 6'h20, 16'h00F3);
      rdchk("R11 flags untouched", 6'h10, 16'h0053);
      chk("R11 tx_irq untouched", {31'h0, tx_irq}, 1);

      // R12 set beats clear in the same cycle
      wr(6'h08, 16'h0040);
      wr(6'h10, 16'h0000);
      chk("R12 irq low before", {31'h0, rx_irq}, 0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 16'h0000;
      ev_brk = 1'b1; ev_rx_full = 1'b1; ev_rx_ready = 1'b1;
      @(posedge clk);
      #1 begin bus_wr = 1'b0; ev_brk = 1'b0; ev_rx_full = 1'b0; ev_rx_ready = 1'b0; end
      chk("R12 irq set wins over status clear", {31'h0, rx_irq}, 1);
      rdchk("R12 flags set win over clear", 6'h10, 16'h0013);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 16'h0000; ev_rx_full = 1'b1;
      @(posedge clk);
      #1 begin bus_wr = 1'b0; ev_rx_full = 1'b0; end
      chk("R12 irq set wins over control clear", {31'h0, rx_irq}, 1);
      rdchk("R12 status after collision", 6'h10, 16'h0053);
      wr(6'h08, 16'h0000);
      #1 chk("R12 irq falls once alone", {31'h0, rx_irq}, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule